// File: doc/BRIEF.md
# Double-Buffered DAC Holding Register Bank

This block holds the digital codes for an eight-channel, 12-bit voltage DAC. Each channel has two register stages. A staging register is loaded from a parallel write port, which carries a channel index, a data word and a strobe. An output register feeds the converter. The contents of all output registers leave the block as one flat vector, with channel 0 in the lowest 12 bits.

An active-low load input moves staged data into the output registers. Only channels written since their last transfer are moved, and all of them change in the same clock cycle. If the load input is held low, each output follows its staging register one cycle after the write.

An active-low clear input acts on its falling edge. It forces both stages of every channel to a code chosen by a 2-bit clear-select register, and it discards staged data. While the clear input stays low, load requests are ignored. Both control inputs are asynchronous and pass through a two-flop synchronizer before use.

Top module: `dac_hold_bank`

## Requirements
- R1: After reset every output register reads 0x000, and a load request with no prior write leaves every output at 0x000.
- R2: A write with the load input high updates only the staging register, so `dac_o` does not change.
- R3: A low pulse on `load_ni` copies every staged channel into its output register in one cycle. Channels that were not written keep their value.
- R4: While `load_ni` is held low, a write reaches `dac_o` on the second rising edge after it is sampled, not on the first.
- R5: A falling edge on `clear_ni` sets every channel of `dac_o` to the clear code. The codes are select 00 → 0x000, 01 → 0x800, 10 → 0xFFF and 11 → 0x000.
- R6: A clear also loads the clear code into every staging register and discards pending writes, so a later load keeps the clear code on `dac_o`.
- R7: While `clear_ni` stays low, load requests have no effect. Writes made during that time are still staged and transfer on the first load after `clear_ni` returns high.
- R8: If a write and a clear edge fall in the same cycle, the clear wins and the write is lost.
- R9: The clear-select register resets to 00, so a clear before any select write drives the outputs to 0x000.
- R10: A change on `load_ni` or `clear_ni` reaches `dac_o` on the third rising clock edge after the change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for a staging register |
| wr_ch_i | input | 3 | Channel index of the write |
| wr_data_i | input | 12 | Write data |
| cc_we_i | input | 1 | Write strobe for the clear-select register |
| cc_sel_i | input | 2 | Clear-select value (00 zero, 01 mid, 10 full, 11 zero) |
| load_ni | input | 1 | Asynchronous load request, active low |
| clear_ni | input | 1 | Asynchronous clear, acts on its falling edge |
| dac_o | output | 96 | Output register contents, channel n in bits [12n+11:12n] |

## Verification
The assertions assume that each level of `load_ni` and `clear_ni` lasts at least two clock cycles, so that the synchronized copies see every edge. They also assume that `wr_ch_i` is valid whenever `wr_en_i` is high. The bench drives every input on the falling clock edge and holds each control level for at least two cycles, so both assumptions always hold. For the same-cycle race, the bench counts the synchronizer delay and places the write strobe in the cycle where the clear edge is detected.

// File: rtl/dac_hold_pkg.sv
package dac_hold_pkg;
  typedef enum logic [1:0] {
    CC_ZERO = 2'b00,
    CC_MID  = 2'b01,
    CC_FULL = 2'b10,
    CC_RSVD = 2'b11
  } clr_sel_e;

  function automatic logic [11:0] clr_code(input clr_sel_e sel);
    case (sel)
      CC_MID:  clr_code = 12'h800;
      CC_FULL: clr_code = 12'hFFF;
      default: clr_code = 12'h000;
    endcase
  endfunction
endpackage

// File: rtl/dac_sync_fall.sv
module dac_sync_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hit_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_act_i,
  input  logic              clr_fall_i,
  input  logic [DATA_W-1:0] clr_val_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              pend_o
);
  logic [DATA_W-1:0] in_q, dac_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      dac_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_fall_i) begin
      // clear beats a concurrent write
      in_q   <= clr_val_i;
      dac_q  <= clr_val_i;
      pend_q <= 1'b0;
    end else begin
      if (load_act_i && pend_q) begin
        dac_q  <= in_q;
        pend_q <= 1'b0;
      end
      if (wr_hit_i) begin
        in_q   <= wr_data_i;
        pend_q <= 1'b1;
      end
    end
  end

  assign dac_o  = dac_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/dac_hold_bank.sv
module dac_hold_bank #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned OUT_W      = NUM_CH * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              cc_we_i,
  input  logic [1:0]        cc_sel_i,
  input  logic              load_ni,
  input  logic              clear_ni,
  output logic [OUT_W-1:0]  dac_o
);
  import dac_hold_pkg::*;

  logic        load_s, load_fall_unused;
  logic        clr_s, clr_fall;
  logic        load_act;
  clr_sel_e    cc_q;
  logic [DATA_W-1:0] clr_val;
  logic [NUM_CH-1:0] pend_q;

  dac_sync_fall #(.STAGES(SYNC_STAGES)) i_sync_load (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(load_ni),
    .level_o(load_s), .fall_o(load_fall_unused)
  );

  dac_sync_fall #(.STAGES(SYNC_STAGES)) i_sync_clr (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(clear_ni),
    .level_o(clr_s), .fall_o(clr_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cc_q <= CC_ZERO;
    else if (cc_we_i) cc_q <= clr_sel_e'(cc_sel_i);
  end

  // 12-bit codes; wider data keeps the same fraction of full scale
  always_comb begin
    clr_val = '0;
    case (cc_q)
      CC_MID:  clr_val[DATA_W-1] = 1'b1;
      CC_FULL: clr_val = '1;
      default: clr_val = '0;
    endcase
  end

  // load is level sensitive and blocked while clear is held low
  assign load_act = ~load_s & clr_s;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan #(.DATA_W(DATA_W)) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_hit_i   (wr_en_i && (wr_ch_i == CH_W'(g))),
      .wr_data_i  (wr_data_i),
      .load_act_i (load_act),
      .clr_fall_i (clr_fall),
      .clr_val_i  (clr_val),
      .dac_o      (dac_o[g*DATA_W +: DATA_W]),
      .pend_o     (pend_q[g])
    );
  end
endmodule

// File: rtl/dac_hold_bank_chk.sv
module dac_hold_bank_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned OUT_W  = 96
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              load_s,
  input logic              clr_s,
  input logic              clr_fall,
  input logic [NUM_CH-1:0] pend_q,
  input logic [OUT_W-1:0]  dac_o
);
  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_s && !clr_fall) |=> $stable(dac_o)); // R2

  AST_CLR_BLOCKS_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_s && !clr_fall) |=> $stable(dac_o)); // R7

  AST_CLR_DROPS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fall |=> (pend_q == '0)); // R6

  AST_CLR_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_fall |=> (dac_o[DATA_W-1:0] == '0 || dac_o[DATA_W-1:0] == '1 ||
                  dac_o[DATA_W-1:0] == {1'b1, {(DATA_W-1){1'b0}}})); // R5

  AST_WRITE_STAGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !clr_fall) |=> (pend_q != '0)); // R2

  AST_RACE_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && clr_fall) |=> (pend_q == '0)); // R8
endmodule

bind dac_hold_bank dac_hold_bank_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .OUT_W(OUT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .load_s(load_s),
  .clr_s(clr_s), .clr_fall(clr_fall), .pend_q(pend_q), .dac_o(dac_o)
);

// File: tb/test_dac_hold_bank.sv
module test_dac_hold_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_ch_i = '0;
  logic [11:0] wr_data_i = '0;
  logic        cc_we_i = 1'b0;
  logic [1:0]  cc_sel_i = '0;
  logic        load_ni = 1'b1;
  logic        clear_ni = 1'b1;
  logic [95:0] dac_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dac_hold_bank i_dac_hold_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i),
    .wr_data_i(wr_data_i), .cc_we_i(cc_we_i), .cc_sel_i(cc_sel_i),
    .load_ni(load_ni), .clear_ni(clear_ni), .dac_o(dac_o)
  );

  function automatic logic [11:0] ch(input int n);
    return dac_o[n*12 +: 12];
  endfunction

  task automatic check(input string req, input logic [95:0] got, input logic [95:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic write_ch(input int c, input logic [11:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_ch_i = 3'(c); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic set_cc(input logic [1:0] s);
    @(negedge clk_i);
    cc_we_i = 1'b1; cc_sel_i = s;
    @(negedge clk_i);
    cc_we_i = 1'b0;
  endtask

  task automatic pulse_load();
    @(negedge clk_i); load_ni = 1'b0;
    cyc(2); load_ni = 1'b1;
    cyc(4);
  endtask

  task automatic pulse_clear();
    @(negedge clk_i); clear_ni = 1'b0;
    cyc(3); clear_ni = 1'b1;
    cyc(4);
  endtask

  function automatic logic [95:0] all_of(input logic [11:0] v);
    return {8{v}};
  endfunction

  task automatic t_reset();
    check("R1 reset", dac_o, '0);
    pulse_load();
    check("R1 load after reset", dac_o, '0);
    write_ch(1, 12'h7FF);
    pulse_load();
    check("R1 ch1 loaded", {84'h0, ch(1)}, {84'h0, 12'h7FF});
    pulse_clear();
    check("R9 default clear zero", dac_o, '0);
  endtask

  task automatic t_write_hold();
    write_ch(2, 12'h123);
    write_ch(5, 12'hABC);
    cyc(4);
    check("R2 no change without load", dac_o, '0);
  endtask

  task automatic t_load_pulse();
    logic [95:0] exp = '0;
    exp[2*12 +: 12] = 12'h123;
    exp[5*12 +: 12] = 12'hABC;
    pulse_load();
    check("R3 staged channels loaded", dac_o, exp);
    write_ch(2, 12'h456);
    pulse_load();
    exp[2*12 +: 12] = 12'h456;
    check("R3 only staged channel changes", dac_o, exp);
  endtask

  task automatic t_load_tied();
    @(negedge clk_i); load_ni = 1'b0;
    cyc(4);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_ch_i = 3'd0; wr_data_i = 12'h321;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R4 not after first edge", {84'h0, ch(0)}, 96'h0);
    @(negedge clk_i);
    check("R4 after second edge", {84'h0, ch(0)}, {84'h0, 12'h321});
    write_ch(7, 12'h0AA);
    @(negedge clk_i);
    check("R4 second write follows", {84'h0, ch(7)}, {84'h0, 12'h0AA});
    load_ni = 1'b1;
    cyc(4);
  endtask

  task automatic t_clear_codes();
    logic [11:0] codes [4] = '{12'h000, 12'h800, 12'hFFF, 12'h000};
    for (int s = 0; s < 4; s++) begin
      write_ch(3, 12'h5A5);
      pulse_load();
      set_cc(2'(s));
      @(negedge clk_i); clear_ni = 1'b0;
      @(negedge clk_i); @(negedge clk_i);
      check("R10 clear not before third edge", {84'h0, ch(3)}, {84'h0, 12'h5A5});
      @(negedge clk_i);
      check("R5 clear code", dac_o, all_of(codes[s]));
      clear_ni = 1'b1;
      cyc(4);
    end
  endtask

  task automatic t_load_timing();
    write_ch(6, 12'h3C3);
    @(negedge clk_i); load_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    check("R10 load not before third edge", {84'h0, ch(6)}, 96'h0);
    @(negedge clk_i);
    check("R10 load on third edge", {84'h0, ch(6)}, {84'h0, 12'h3C3});
    load_ni = 1'b1;
    cyc(4);
  endtask

  task automatic t_clear_pend();
    set_cc(2'b01);
    write_ch(3, 12'h055);
    pulse_clear();
    set_cc(2'b10);
    pulse_load();
    check("R6 staged data discarded", dac_o, all_of(12'h800));
  endtask

  task automatic t_clear_blocks();
    set_cc(2'b00);
    @(negedge clk_i); clear_ni = 1'b0;
    cyc(4);
    write_ch(4, 12'h0F0);
    pulse_load();
    check("R7 load ignored while clear low", dac_o, '0);
    clear_ni = 1'b1;
    cyc(4);
    check("R7 release alone changes nothing", dac_o, '0);
    pulse_load();
    check("R7 staged write transfers later", {84'h0, ch(4)}, {84'h0, 12'h0F0});
  endtask

  task automatic t_race();
    set_cc(2'b10);
    @(negedge clk_i); clear_ni = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    wr_en_i = 1'b1; wr_ch_i = 3'd6; wr_data_i = 12'h111;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check("R8 clear applied", dac_o, all_of(12'hFFF));
    clear_ni = 1'b1;
    cyc(4);
    pulse_load();
    check("R8 racing write lost", dac_o, all_of(12'hFFF));
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    t_reset();
    t_write_hold();
    t_load_pulse();
    t_load_tied();
    t_load_timing();
    t_clear_codes();
    t_clear_pend();
    t_clear_blocks();
    t_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog expired got=running exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule